// File: doc/BRIEF.md
# Handshaked Byte-Serial Link Controller

This block is the host end of a half-duplex, byte-wide serial link to a peripheral microcontroller. It drives an active-low transfer-in-progress line and an acknowledge line, and it watches an active-low request line from the peripheral. The bytes themselves pass through an external 8-bit shift unit. The controller selects the unit's direction, hands it a byte with a one-cycle load pulse and is told when a byte has moved by a one-cycle done pulse.

To send, the host writes a frame into the transmit buffer and raises a send request with the frame length. After a settle delay the controller shifts the frame out one byte at a time. The peripheral may also start a frame of its own at any time. The controller then stores it in the receive buffer and reports its length and first (type) byte with a one-cycle strobe. If the peripheral requests the link while a send is under way, the controller gives way, takes in the incoming frame, waits a gap and sends the whole frame again. Delays are counted in microseconds by a prescaler of `CLK_PER_US` clocks.

Top module: `serial_link_ctrl`

## Requirements
- R1: Out of reset and whenever the link is idle, `tip_no` is 1, `ack_o` is 1 and `sr_dir_out_o` is 0 (receive direction).
- R2: An accepted send request in idle produces, after `SETTLE_US*CLK_PER_US+1` cycles, one `sr_load_o` pulse carrying transmit byte 0. At the same time `sr_dir_out_o` goes to 1, `ack_o` is 1 and `tip_no` goes to 0.
- R3: While sending with `req_ni` at 1, each `sr_done_i` loads the next byte and inverts `ack_o`. The done for the last byte instead pulses `send_done_o` and returns the link to idle (`tip_no`=1, `ack_o`=1, receive direction). This includes a 1-byte frame.
- R4: When `sr_done_i` arrives with no transfer active and `req_ni` at 0, the shifted byte is kept as the frame type and `tip_no` goes to 0 with `sr_dir_out_o` at 0. `ack_o` is not changed for this first byte.
- R5: While receiving, each byte is stored at the next receive-buffer address, starting from address 0 for the type byte. A done with `req_ni` still at 0 inverts `ack_o`. A done with `req_ni` at 1 ends the frame: `frame_valid_o` pulses with `frame_len_o` equal to the byte count and `frame_type_o` equal to byte 0, and `tip_no` returns to 1.
- R6: A done with no transfer active and `req_ni` at 1 is a false start. No frame is reported, `tip_no` stays 1, and when no send is pending the link stays idle.
- R7: If `req_ni` is 0 at a done during a send, the send is abandoned without `send_done_o` and the controller enters receive with that byte as the type. The send stays pending and is later restarted from byte 0.
- R8: After a frame ends with a send pending, the controller waits `GAP_US*CLK_PER_US+1` cycles and then loads byte 0. If `req_ni` is 0 at that point, it stays idle and receives instead, and sends after that frame.
- R9: Only one send may be pending. A send request while one is pending pulses `send_refused_o` in the next cycle and has no other effect.
- R10: The receive buffer holds `DEPTH` bytes. A done that arrives with the buffer full pulses `ovf_err_o` once and ends the frame, with `frame_len_o` equal to `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txb_we_i | input | 1 | Transmit buffer write enable |
| txb_addr_i | input | AW | Transmit buffer write address |
| txb_data_i | input | 8 | Transmit buffer write data |
| send_req_i | input | 1 | Request to send the buffered frame |
| send_len_i | input | AW+1 | Frame length in bytes, 1 to DEPTH |
| send_refused_o | output | 1 | Request refused, a send is already pending |
| send_done_o | output | 1 | Last byte of the frame has been shifted |
| sr_dir_out_o | output | 1 | Shift unit direction, 1 = out |
| sr_load_o | output | 1 | Load pulse for `sr_wdata_o` |
| sr_wdata_o | output | 8 | Byte to shift out |
| sr_rdata_i | input | 8 | Byte shifted in |
| sr_done_i | input | 1 | Byte-done pulse from the shift unit |
| tip_no | output | 1 | Transfer in progress, active low |
| ack_o | output | 1 | Acknowledge line |
| req_ni | input | 1 | Peripheral request, active low |
| frame_valid_o | output | 1 | Received frame strobe |
| frame_len_o | output | AW+1 | Received frame length |
| frame_type_o | output | 8 | First byte of the received frame |
| ovf_err_o | output | 1 | Receive overflow strobe |
| rxb_addr_i | input | AW | Receive buffer read address |
| rxb_data_o | output | 8 | Receive buffer read data |

## Verification
The hardest case to reach is a receive that must wait behind a pending send. The send has to become pending while a frame is still arriving, and the request line has to fall again inside the gap that follows. The bench issues a send request between two received bytes, drops `req_ni` one cycle after the frame strobe, and confirms that no byte is loaded across the whole gap. It then delivers a second frame and checks that the send starts exactly one gap later. Collision uses the same peripheral model: it pulls the request low on the first transmitted byte and checks that the retry reloads byte 0.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_OUT,
    ST_IN,
    ST_GAP
  } link_st_e;
endpackage

// File: rtl/link_delay.sv
module link_delay #(
  parameter int CLK_PER_US = 250,
  parameter int SHORT_US   = 150,
  parameter int LONG_US    = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  output logic expire_o
);
  localparam int MAXU = (LONG_US > SHORT_US) ? LONG_US : SHORT_US;
  localparam int PW   = $clog2(CLK_PER_US + 1);
  localparam int UW   = $clog2(MAXU + 1);
  localparam logic [PW-1:0] PMAX = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q, tgt_q;
  logic          busy_q;

  assign expire_o = busy_q && (pre_q == PMAX) && (us_q == tgt_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      us_q   <= '0;
      tgt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      pre_q  <= '0;
      us_q   <= '0;
      tgt_q  <= long_i ? UW'(LONG_US) : UW'(SHORT_US);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (pre_q == PMAX) begin
        pre_q <= '0;
        if (expire_o) busy_q <= 1'b0;
        else          us_q   <= us_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // restart always clears a pending expiry for at least one cycle
  a_r8_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && CLK_PER_US > 1) |=> !expire_o);
endmodule

// File: rtl/link_buf.sv
module link_buf #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/serial_link_ctrl.sv
module serial_link_ctrl
  import link_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int CLK_PER_US = 250,
  parameter int SETTLE_US  = 150,
  parameter int GAP_US     = 1500,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          txb_we_i,
  input  logic [AW-1:0] txb_addr_i,
  input  logic [7:0]    txb_data_i,
  input  logic          send_req_i,
  input  logic [CW-1:0] send_len_i,
  output logic          send_refused_o,
  output logic          send_done_o,
  output logic          sr_dir_out_o,
  output logic          sr_load_o,
  output logic [7:0]    sr_wdata_o,
  input  logic [7:0]    sr_rdata_i,
  input  logic          sr_done_i,
  output logic          tip_no,
  output logic          ack_o,
  input  logic          req_ni,
  output logic          frame_valid_o,
  output logic [CW-1:0] frame_len_o,
  output logic [7:0]    frame_type_o,
  output logic          ovf_err_o,
  input  logic [AW-1:0] rxb_addr_i,
  output logic [7:0]    rxb_data_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  link_st_e      st_q;
  logic          pend_q, dly_go_q, dly_long_q;
  logic [CW-1:0] len_q, sent_q, rx_cnt_q;
  logic [7:0]    type_q;

  logic          accept, pend_eff, idle_like, rx_full, rx_we, launch;
  logic          dly_exp, tmr_exp;
  logic [CW-1:0] sent_n;
  logic [AW-1:0] tx_raddr, rx_waddr;
  logic [7:0]    tx_rdata;

  link_buf #(.DEPTH(DEPTH), .AW(AW)) u_txb (
    .clk_i, .we_i(txb_we_i), .waddr_i(txb_addr_i), .wdata_i(txb_data_i),
    .raddr_i(tx_raddr), .rdata_o(tx_rdata)
  );

  link_buf #(.DEPTH(DEPTH), .AW(AW)) u_rxb (
    .clk_i, .we_i(rx_we), .waddr_i(rx_waddr), .wdata_i(sr_rdata_i),
    .raddr_i(rxb_addr_i), .rdata_o(rxb_data_o)
  );

  link_delay #(.CLK_PER_US(CLK_PER_US), .SHORT_US(SETTLE_US), .LONG_US(GAP_US)) u_dly (
    .clk_i, .rst_ni, .start_i(dly_go_q), .long_i(dly_long_q), .expire_o(dly_exp)
  );

  always_comb begin
    accept    = send_req_i && !pend_q;
    pend_eff  = pend_q || accept;
    sent_n    = sent_q + 1'b1;
    tx_raddr  = (st_q == ST_OUT) ? sent_n[AW-1:0] : '0;
    idle_like = (st_q == ST_IDLE) || (st_q == ST_SETTLE) || (st_q == ST_GAP);
    rx_full   = (rx_cnt_q == FULL);
    rx_we     = sr_done_i && (idle_like || (st_q == ST_OUT && !req_ni) ||
                              (st_q == ST_IN && !rx_full));
    rx_waddr  = (st_q == ST_IN) ? rx_cnt_q[AW-1:0] : '0;
    // an expiry seen while a restart is queued belongs to the old interval
    tmr_exp   = dly_exp && !dly_go_q;
    launch    = !sr_done_i && tmr_exp &&
                ((st_q == ST_SETTLE) || (st_q == ST_GAP && req_ni));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= ST_IDLE;
      pend_q         <= 1'b0;
      len_q          <= '0;
      sent_q         <= '0;
      rx_cnt_q       <= '0;
      type_q         <= '0;
      dly_go_q       <= 1'b0;
      dly_long_q     <= 1'b0;
      tip_no         <= 1'b1;
      ack_o          <= 1'b1;
      sr_dir_out_o   <= 1'b0;
      sr_load_o      <= 1'b0;
      sr_wdata_o     <= '0;
      send_done_o    <= 1'b0;
      send_refused_o <= 1'b0;
      frame_valid_o  <= 1'b0;
      frame_len_o    <= '0;
      frame_type_o   <= '0;
      ovf_err_o      <= 1'b0;
    end else begin
      sr_load_o      <= 1'b0;
      send_done_o    <= 1'b0;
      frame_valid_o  <= 1'b0;
      ovf_err_o      <= 1'b0;
      dly_go_q       <= 1'b0;
      send_refused_o <= send_req_i && pend_q;
      if (accept) begin
        pend_q <= 1'b1;
        len_q  <= send_len_i;
      end

      if (launch) begin
        st_q         <= ST_OUT;
        sent_q       <= '0;
        sr_dir_out_o <= 1'b1;
        sr_wdata_o   <= tx_rdata;
        sr_load_o    <= 1'b1;
        ack_o        <= 1'b1;
        tip_no       <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE, ST_SETTLE, ST_GAP: begin
            if (sr_done_i) begin
              type_q <= sr_rdata_i;
              if (!req_ni) begin
                st_q         <= ST_IN;
                rx_cnt_q     <= CW'(1);
                sr_dir_out_o <= 1'b0;
                tip_no       <= 1'b0;
              end else if (pend_eff) begin
                st_q       <= ST_SETTLE;   // false start, rearm the send
                dly_go_q   <= 1'b1;
                dly_long_q <= 1'b0;
              end else begin
                st_q <= ST_IDLE;
              end
            end else if (st_q == ST_IDLE && accept) begin
              st_q       <= ST_SETTLE;
              dly_go_q   <= 1'b1;
              dly_long_q <= 1'b0;
            end else if (st_q == ST_GAP && tmr_exp) begin
              st_q <= ST_IDLE;             // request seen, receive first
            end
          end

          ST_OUT: begin
            if (sr_done_i) begin
              if (!req_ni) begin
                type_q       <= sr_rdata_i;
                rx_cnt_q     <= CW'(1);
                sent_q       <= '0;
                st_q         <= ST_IN;
                sr_dir_out_o <= 1'b0;
                tip_no       <= 1'b0;
                ack_o        <= 1'b1;
              end else if (sent_n == len_q) begin
                pend_q       <= 1'b0;
                send_done_o  <= 1'b1;
                st_q         <= ST_IDLE;
                sr_dir_out_o <= 1'b0;
                tip_no       <= 1'b1;
                ack_o        <= 1'b1;
              end else begin
                sent_q     <= sent_n;
                sr_wdata_o <= tx_rdata;
                sr_load_o  <= 1'b1;
                ack_o      <= ~ack_o;
              end
            end
          end

          ST_IN: begin
            if (sr_done_i) begin
              if (rx_full) ovf_err_o <= 1'b1;
              else         rx_cnt_q  <= rx_cnt_q + 1'b1;
              if (rx_full || req_ni) begin
                frame_valid_o <= 1'b1;
                frame_len_o   <= rx_full ? rx_cnt_q : rx_cnt_q + 1'b1;
                frame_type_o  <= type_q;
                tip_no        <= 1'b1;
                ack_o         <= 1'b1;
                sr_dir_out_o  <= 1'b0;
                if (pend_eff) begin
                  st_q       <= ST_GAP;
                  dly_go_q   <= 1'b1;
                  dly_long_q <= 1'b1;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                ack_o <= ~ack_o;
              end
            end
          end

          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> (tip_no && ack_o && !sr_dir_out_o));

  a_r2_load_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_load_o |-> (sr_dir_out_o && !tip_no));

  a_r3_done_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_done_o |-> (tip_no && !sr_dir_out_o && ack_o));

  a_r5_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> (frame_len_o != '0 && frame_len_o <= FULL));

  a_r7_yield: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OUT && sr_done_i && !req_ni) |=> (!send_done_o && !sr_dir_out_o && !tip_no));

  a_r9_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_req_i && pend_q) |=> send_refused_o);

  a_r10_ovf_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |-> (frame_valid_o && frame_len_o == FULL));
endmodule

// File: tb/serial_link_ctrl_test.sv
module serial_link_ctrl_test;
  localparam int DEPTH = 256;
  localparam int CPU   = 2;
  localparam int SET   = 3;
  localparam int GAP   = 5;
  localparam int AW    = 8;

  logic clk_i = 0, rst_ni = 0;
  logic txb_we_i = 0, send_req_i = 0, sr_done_i = 0, req_ni = 1;
  logic [AW-1:0] txb_addr_i = '0, rxb_addr_i = '0;
  logic [7:0] txb_data_i = '0, sr_rdata_i = '0;
  logic [AW:0] send_len_i = '0;
  logic send_refused_o, send_done_o, sr_dir_out_o, sr_load_o, tip_no, ack_o;
  logic frame_valid_o, ovf_err_o;
  logic [7:0] sr_wdata_o, frame_type_o, rxb_data_o;
  logic [AW:0] frame_len_o;

  int vecs = 0, fails = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  serial_link_ctrl #(.DEPTH(DEPTH), .CLK_PER_US(CPU), .SETTLE_US(SET), .GAP_US(GAP)) uut (.*);

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'(s * 37 + k * 11 + 5);
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  task automatic pulse_done(input logic [7:0] b, input logic rq);
    @(negedge clk_i); sr_rdata_i = b; req_ni = rq; sr_done_i = 1;
    @(negedge clk_i); sr_done_i = 0;
  endtask

  task automatic load_tx(input int s, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); txb_we_i = 1; txb_addr_i = AW'(k); txb_data_i = pat(s, k);
    end
    @(negedge clk_i); txb_we_i = 0;
  endtask

  task automatic req_send(input int n);
    @(negedge clk_i); send_req_i = 1; send_len_i = (AW+1)'(n);
    @(negedge clk_i); send_req_i = 0;
  endtask

  task automatic wait_load(output int c);
    c = 0;
    while (!sr_load_o && c < 200) begin @(negedge clk_i); c++; end
  endtask

  // byte 0 load is visible now; shift the rest out
  task automatic pump(input int s, input int n);
    logic ab;
    chk(sr_wdata_o == pat(s, 0), "R2 byte0", sr_wdata_o, pat(s, 0));
    chk(sr_dir_out_o && !tip_no && ack_o, "R2 lines", {sr_dir_out_o, tip_no, ack_o}, 3'b101);
    for (int k = 0; k < n; k++) begin
      ab = ack_o;
      pulse_done(8'h00, 1'b1);
      if (k < n - 1) begin
        chk(sr_load_o && sr_wdata_o == pat(s, k + 1), "R3 next byte", sr_wdata_o, pat(s, k + 1));
        chk(ack_o == ~ab, "R3 ack toggle", ack_o, ~ab);
      end else begin
        chk(send_done_o, "R3 send_done", send_done_o, 1);
        chk(tip_no && ack_o && !sr_dir_out_o, "R3 idle after send",
            {sr_dir_out_o, tip_no, ack_o}, 3'b011);
      end
    end
  endtask

  task automatic t_send(input int s, input int n);
    int c;
    load_tx(s, n);
    req_send(n);
    wait_load(c);
    chk(c == SET * CPU + 1, "R2 settle cycles", c, SET * CPU + 1);
    pump(s, n);
  endtask

  task automatic t_recv(input int s, input int n);
    logic ab;
    pulse_done(pat(s, 0), 1'b0);
    chk(!tip_no && !sr_dir_out_o && ack_o && !frame_valid_o, "R4 rx start",
        {tip_no, sr_dir_out_o, ack_o}, 3'b001);
    for (int k = 1; k < n; k++) begin
      ab = ack_o;
      pulse_done(pat(s, k), (k == n - 1));
      if (k < n - 1) chk(ack_o == ~ab && !frame_valid_o, "R5 ack toggle", ack_o, ~ab);
    end
    chk(frame_valid_o && frame_len_o == (AW+1)'(n), "R5 frame len", frame_len_o, n);
    chk(frame_type_o == pat(s, 0), "R5 frame type", frame_type_o, pat(s, 0));
    chk(tip_no && ack_o, "R5 tip release", {tip_no, ack_o}, 2'b11);
    for (int k = 0; k < n; k++) begin
      rxb_addr_i = AW'(k); #1;
      chk(rxb_data_o == pat(s, k), "R5 rx buffer", rxb_data_o, pat(s, k));
    end
  endtask

  task automatic t_false();
    pulse_done(8'h55, 1'b1);
    chk(tip_no && !frame_valid_o, "R6 false start", {tip_no, frame_valid_o}, 2'b10);
    repeat (3) @(negedge clk_i);
    chk(tip_no && ack_o && !sr_load_o && !frame_valid_o, "R6 still idle",
        {tip_no, ack_o, sr_load_o}, 3'b110);
  endtask

  task automatic t_refuse();
    int c;
    load_tx(9, 2);
    @(negedge clk_i); send_req_i = 1; send_len_i = 2;
    @(negedge clk_i);
    @(negedge clk_i); send_req_i = 0;
    chk(send_refused_o, "R9 refused", send_refused_o, 1);
    wait_load(c);
    chk(c == SET * CPU, "R9 first send unaffected", c, SET * CPU);
    pump(9, 2);
    req_send(2);
    chk(!send_refused_o, "R9 accepted after done", send_refused_o, 0);
    wait_load(c);
    pump(9, 2);
  endtask

  task automatic t_collision();
    int c;
    load_tx(4, 3);
    req_send(3);
    wait_load(c);
    pulse_done(8'hC5, 1'b0);
    chk(!send_done_o && !sr_dir_out_o && !tip_no && !sr_load_o, "R7 yield",
        {send_done_o, sr_dir_out_o, tip_no, sr_load_o}, 0);
    pulse_done(8'h3A, 1'b1);
    chk(frame_valid_o && frame_len_o == 2 && frame_type_o == 8'hC5, "R7 rx during send",
        frame_type_o, 8'hC5);
    wait_load(c);
    chk(c == GAP * CPU + 1, "R8 gap cycles", c, GAP * CPU + 1);
    pump(4, 3);  // R7 retry from byte 0
  endtask

  task automatic t_gap_block();
    int c;
    bit seen;
    load_tx(6, 2);
    pulse_done(8'h77, 1'b0);
    @(negedge clk_i); send_req_i = 1; send_len_i = 2;
    @(negedge clk_i); send_req_i = 0;
    pulse_done(8'h11, 1'b1);
    chk(frame_valid_o && frame_len_o == 2, "R8 first frame", frame_len_o, 2);
    @(negedge clk_i); req_ni = 0;
    seen = 0;
    repeat (20) begin @(negedge clk_i); if (sr_load_o) seen = 1; end
    chk(!seen && tip_no, "R8 no send while requested", seen, 0);
    pulse_done(8'h22, 1'b0);
    chk(!tip_no && !sr_dir_out_o, "R8 receive instead", tip_no, 0);
    pulse_done(8'h33, 1'b1);
    chk(frame_valid_o && frame_type_o == 8'h22, "R8 second frame", frame_type_o, 8'h22);
    wait_load(c);
    chk(c == GAP * CPU + 1, "R8 send after frame", c, GAP * CPU + 1);
    pump(6, 2);
  endtask

  task automatic t_overflow();
    int nv = 0;
    for (int k = 0; k < DEPTH; k++) begin
      pulse_done(pat(2, k), 1'b0);
      if (frame_valid_o) nv++;
    end
    chk(nv == 0 && !tip_no, "R10 full but open", nv, 0);
    pulse_done(8'hEE, 1'b0);
    chk(ovf_err_o && frame_valid_o, "R10 overflow strobe", {ovf_err_o, frame_valid_o}, 2'b11);
    chk(frame_len_o == (AW+1)'(DEPTH), "R10 length", frame_len_o, DEPTH);
    chk(tip_no, "R10 frame forced end", tip_no, 1);
    @(negedge clk_i); req_ni = 1;
    chk(!ovf_err_o, "R10 once", ovf_err_o, 0);
    rxb_addr_i = AW'(DEPTH - 1); #1;
    chk(rxb_data_o == pat(2, DEPTH - 1), "R10 last byte kept", rxb_data_o, pat(2, DEPTH - 1));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(tip_no && ack_o && !sr_dir_out_o && !frame_valid_o, "R1 reset lines",
        {tip_no, ack_o, sr_dir_out_o}, 3'b110);
    t_send(1, 3);
    t_send(2, 1);
    t_recv(3, 4);
    t_recv(5, 2);
    t_false();
    t_refuse();
    t_collision();
    t_gap_block();
    t_false();
    t_overflow();
    repeat (2) @(negedge clk_i);
    chk(tip_no && ack_o && !sr_dir_out_o, "R1 idle at end", {tip_no, ack_o, sr_dir_out_o}, 3'b110);
    finished = 1;
    summary();
  end
endmodule